// File: doc/BRIEF.md
# 4PPM Fast Infrared Frame Receiver

This block turns a stream of already aligned infrared chips into bytes. Chips arrive one per strobe. The block watches the line for a fixed start flag and drops that flag once it is found. It reads each following group of four chips as a pulse-position symbol that carries two bits, and packs four symbols into a byte. A fixed stop flag ends the frame. The last four bytes before the stop flag are a CRC-32 frame check sequence. They are checked and never forwarded. Payload bytes leave on a valid/ready stream.

Every frame ends with a verdict in a set of sticky status flags: frame ended, illegal symbol, CRC mismatch, and length fault. A single-cycle clear input reads them out. When an error is found, the rest of the frame is dropped and the block starts hunting for a start flag again. While the local transmitter is active, the receiver is held idle. A partly received frame is then dropped without any status.

Top module: `ppm4_frame_rx`

## Requirements
- R1: After a synchronous active-low reset, `m_valid` and all four status flags are 0, and the block is hunting for a start flag.
- R2: No byte is delivered and no status is set until the last `FLAG_CHIPS` chips match `START_FLAG`. The oldest chip is the MSB. After that match, chips are grouped four at a time.
- R3: A symbol with its chips in arrival order c0..c3 decodes as 1000→00, 0100→01, 0010→10 and 0001→11. The first symbol of a byte gives bits [1:0] and the fourth gives bits [7:6].
- R4: At a symbol boundary, once at least `FLAG_CHIPS` chips have arrived after the start flag, a window equal to `STOP_FLAG` ends the frame and sets `stat_end`. The stop flag chips are never decoded as data.
- R5: A data symbol with any other chip pattern sets `stat_illegal` and `stat_end` and aborts the frame.
- R6: At the stop flag, the CRC register is checked. It uses reflected polynomial 0x04C11DB7, is preset to all ones, and runs over all bytes including the check bytes. If it does not hold the residue 0xDEBB20E3, `stat_crc` is set. This check is made only when the length is valid.
- R7: The last four bytes before the stop flag are held back and never appear on `m_data`.
- R8: `stat_len` and `stat_end` are set in three cases: the frame holds more than `MAX_LEN` payload bytes (the frame aborts when the extra byte completes), the stop flag arrives after fewer than four bytes, or the stop flag arrives after a partial byte.
- R9: While `tx_active` is 1, chips are ignored and the receiver returns to hunting. No byte and no status are produced.
- R10: The status flags stay set until a cycle with `stat_clr` = 1 clears them. A flag that is set in that same cycle stays 1.
- R11: `m_valid` stays 1 with `m_data` stable until `m_ready` is 1. The consumer must accept each byte before the next one is decoded, which is at least 16 chip strobes later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_vld | input | 1 | Strobe: `chip_in` carries one chip this cycle |
| chip_in | input | 1 | Chip value |
| tx_active | input | 1 | Local transmitter busy; holds the receiver idle |
| m_ready | input | 1 | Consumer accepts `m_data` |
| m_valid | output | 1 | Payload byte available |
| m_data | output | 8 | Payload byte |
| stat_clr | input | 1 | Read strobe; clears the status flags |
| stat_end | output | 1 | A frame ended with a verdict |
| stat_illegal | output | 1 | Illegal symbol seen |
| stat_crc | output | 1 | Frame check mismatch |
| stat_len | output | 1 | Frame too long, too short or not byte aligned |

## Verification
A status read can fall in the same cycle as the last stop-flag chip, which sets the end flag. The bench leaves a CRC error from the previous frame uncleared. It then pulses `stat_clr` together with the final chip of a good frame's stop flag. After that cycle the end flag must read 1 and the stale CRC flag must read 0. A behavioural model of chip windows, dibit queues and a four-byte hold queue is compared against every output on every clock. Per-frame checks compare the received byte lists and status flags with values the bench derives from what it sent.

// File: rtl/ppm4_rx_pkg.sv
// Package: shared types and functions for the 4PPM frame receiver.
// Assumes the caller feeds bytes LSB first into the reflected CRC.
package ppm4_rx_pkg;

    localparam int          FCS_BYTES   = 4;
    localparam logic [31:0] CRC_PRESET  = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_RESIDUE = 32'hDEBB_20E3;
    localparam logic [31:0] CRC_POLY_R  = 32'hEDB8_8320;

    typedef enum logic {ST_HUNT, ST_DATA} rx_state_e;

    typedef struct packed {
        logic       ok;
        logic [1:0] dibit;
    } sym_dec_t;

    // One pulse-position symbol, first chip at bit 3, to a dibit.
    function automatic sym_dec_t ppm_decode(input logic [3:0] s);
        sym_dec_t r;
        r.ok = 1'b1;
        case (s)
            4'b1000: r.dibit = 2'd0;
            4'b0100: r.dibit = 2'd1;
            4'b0010: r.dibit = 2'd2;
            4'b0001: r.dibit = 2'd3;
            default: begin r.ok = 1'b0; r.dibit = 2'd0; end
        endcase
        return r;
    endfunction

    // Reflected CRC-32 register advanced by one byte.
    function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'd0, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/ppm4_chip_window.sv
// Module: sliding window of the most recent chips, oldest chip in the MSB.
// Assumes one chip per shift strobe; a clear empties the window to zeros.
module ppm4_chip_window #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift,
    input  logic             chip,
    output logic [WIDTH-1:0] win_next
);
    logic [WIDTH-1:0] win_q;

    // Window contents once the current chip is included.
    assign win_next = {win_q[WIDTH-2:0], chip};

    // Register the window on every accepted chip.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) win_q <= '0;
        else if (shift)    win_q <= win_next;
    end
endmodule

// File: rtl/ppm4_crc32.sv
// Module: frame check register, preset at frame start, advanced per byte.
// Assumes init and update are never asserted together.
module ppm4_crc32 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        update,
    input  logic [7:0]  data,
    output logic [31:0] crc
);
    import ppm4_rx_pkg::*;

    // Preset or advance the CRC register.
    always_ff @(posedge clk) begin
        if (!rst_n || init) crc <= CRC_PRESET;
        else if (update)    crc <= crc32_byte(crc, data);
    end
endmodule

// File: rtl/ppm4_fcs_strip.sv
// Module: holds back the last DEPTH bytes of a frame so that the check
// bytes never leave; older bytes go to a one-entry valid/ready register.
// Assumes the consumer drains m_valid before the next push that emits.
module ppm4_fcs_strip #(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       push,
    input  logic [7:0] din,
    input  logic       m_ready,
    output logic       m_valid,
    output logic [7:0] m_data
);
    localparam int FILL_W = $clog2(DEPTH + 1);

    logic [7:0]        hold_q [DEPTH];
    logic [FILL_W-1:0] fill_q;
    logic              emit;

    assign emit = push && (fill_q == FILL_W'(DEPTH));

    // Count held bytes up to DEPTH; restart at each frame.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)                      fill_q <= '0;
        else if (push && fill_q != FILL_W'(DEPTH)) fill_q <= fill_q + 1'b1;
    end

    // Hold line: stage 0 takes the new byte, each stage takes its neighbour.
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n)    hold_q[g] <= '0;
            else if (push) hold_q[g] <= (g == 0) ? din : hold_q[(g == 0) ? 0 : g - 1];
        end
    end

    // Output register: load on emit, drop on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 1'b0;
            m_data  <= '0;
        end else if (emit) begin
            m_valid <= 1'b1;
            m_data  <= hold_q[DEPTH-1];
        end else if (m_ready) begin
            m_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/ppm4_frame_rx.sv
// Module: 4PPM frame receiver top. It hunts for the start flag, then decodes
// symbols one flag-length behind the line so that the stop flag is never
// taken as data. It packs dibits into bytes, checks the length and the CRC,
// and latches sticky status. Assumes FLAG_CHIPS is a multiple of 4 and at
// least 8, and that neither flag can be formed by valid data symbols.
module ppm4_frame_rx #(
    parameter int                    FLAG_CHIPS = 16,
    parameter logic [FLAG_CHIPS-1:0] START_FLAG = 16'h0C0C,
    parameter logic [FLAG_CHIPS-1:0] STOP_FLAG  = 16'h0CC0,
    parameter int                    MAX_LEN    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chip_vld,
    input  logic       chip_in,
    input  logic       tx_active,
    input  logic       m_ready,
    output logic       m_valid,
    output logic [7:0] m_data,
    input  logic       stat_clr,
    output logic       stat_end,
    output logic       stat_illegal,
    output logic       stat_crc,
    output logic       stat_len
);
    import ppm4_rx_pkg::*;

    localparam int FLAG_SYMS = FLAG_CHIPS / 4;
    localparam int SYM_W     = $clog2(FLAG_SYMS + 1);
    localparam int LEN_LIMIT = MAX_LEN + FCS_BYTES;
    localparam int LEN_W     = $clog2(LEN_LIMIT + 2);

    rx_state_e             state_q;
    logic [1:0]            phase_q, pair_q;
    logic [SYM_W-1:0]      nsym_q;
    logic [5:0]            acc_q;
    logic [LEN_W-1:0]      nbyte_q;
    logic [FLAG_CHIPS-1:0] win_n;
    logic [31:0]           crc_q;
    logic                  chip_take, frame_start, sym_done, win_full, at_stop;
    logic                  sym_data, bad_sym, byte_done, over_len, push, short_end;
    logic                  set_end, set_ill, set_crc, set_len;
    logic [7:0]            new_byte;
    sym_dec_t              dec;

    assign chip_take = chip_vld && !tx_active;

    ppm4_chip_window #(.WIDTH(FLAG_CHIPS)) u_win (
        .clk(clk), .rst_n(rst_n), .clr(tx_active), .shift(chip_take),
        .chip(chip_in), .win_next(win_n)
    );

    // Frame decisions for the chip taken this cycle.
    always_comb begin
        frame_start = chip_take && state_q == ST_HUNT && win_n == START_FLAG;
        sym_done    = chip_take && state_q == ST_DATA && phase_q == 2'd3;
        win_full    = nsym_q == SYM_W'(FLAG_SYMS - 1);
        at_stop     = sym_done && win_full && win_n == STOP_FLAG;
        dec         = ppm_decode(win_n[FLAG_CHIPS-1 -: 4]);
        sym_data    = sym_done && win_full && !at_stop;
        bad_sym     = sym_data && !dec.ok;
        byte_done   = sym_data && dec.ok && pair_q == 2'd3;
        new_byte    = {dec.dibit, acc_q};
        over_len    = byte_done && nbyte_q == LEN_W'(LEN_LIMIT);
        push        = byte_done && !over_len;
        short_end   = at_stop && (pair_q != 2'd0 || nbyte_q < LEN_W'(FCS_BYTES));
        set_len     = over_len || short_end;
        set_crc     = at_stop && !short_end && crc_q != CRC_RESIDUE;
        set_ill     = bad_sym;
        set_end     = at_stop || bad_sym || over_len;
    end

    // Receive sequencer: hunt, then count chips, symbols, dibits and bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            phase_q <= '0;
            pair_q  <= '0;
            nsym_q  <= '0;
            acc_q   <= '0;
            nbyte_q <= '0;
        end else if (tx_active) begin
            state_q <= ST_HUNT;
        end else if (frame_start) begin
            state_q <= ST_DATA;
            phase_q <= '0;
            pair_q  <= '0;
            nsym_q  <= '0;
            nbyte_q <= '0;
        end else if (set_end) begin
            state_q <= ST_HUNT;
        end else if (chip_take && state_q == ST_DATA) begin
            phase_q <= phase_q + 1'b1;
            if (sym_done && !win_full) nsym_q <= nsym_q + 1'b1;
            if (sym_data) begin
                pair_q <= pair_q + 1'b1;
                acc_q  <= {dec.dibit, acc_q[5:2]};
            end
            if (push) nbyte_q <= nbyte_q + 1'b1;
        end
    end

    ppm4_crc32 u_crc (
        .clk(clk), .rst_n(rst_n), .init(frame_start), .update(push),
        .data(new_byte), .crc(crc_q)
    );

    ppm4_fcs_strip #(.DEPTH(FCS_BYTES)) u_strip (
        .clk(clk), .rst_n(rst_n), .flush(frame_start), .push(push),
        .din(new_byte), .m_ready(m_ready), .m_valid(m_valid), .m_data(m_data)
    );

    // Sticky status: a read clears, a same-cycle set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_end     <= 1'b0;
            stat_illegal <= 1'b0;
            stat_crc     <= 1'b0;
            stat_len     <= 1'b0;
        end else begin
            stat_end     <= (stat_end     && !stat_clr) || set_end;
            stat_illegal <= (stat_illegal && !stat_clr) || set_ill;
            stat_crc     <= (stat_crc     && !stat_clr) || set_crc;
            stat_len     <= (stat_len     && !stat_clr) || set_len;
        end
    end
endmodule

// File: rtl/ppm4_frame_rx_chk.sv
// Checker: port-level temporal properties of ppm4_frame_rx, bound below.
module ppm4_frame_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       chip_vld,
    input logic       chip_in,
    input logic       tx_active,
    input logic       m_ready,
    input logic       m_valid,
    input logic [7:0] m_data,
    input logic       stat_clr,
    input logic       stat_end,
    input logic       stat_illegal,
    input logic       stat_crc,
    input logic       stat_len
);
    // R9: a busy transmitter blocks new bytes
    p_tx_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |=> !$rose(m_valid));
    // R9: a busy transmitter blocks new status
    p_tx_nostat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |=> !$rose(stat_end));
    // R5: an illegal symbol ends the frame
    p_ill_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_illegal) |-> stat_end);
    // R6: a CRC verdict comes with frame end
    p_crc_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_crc) |-> stat_end);
    // R8: a length verdict comes with frame end
    p_len_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_len) |-> stat_end);
    // R10: flags hold while not read
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_end && !stat_clr |=> stat_end);
    // R10: a read with no chip clears every flag
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr && !chip_vld |=> !stat_end && !stat_illegal && !stat_crc && !stat_len);
    // R11: a pending byte stays put until accepted
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !m_ready && !chip_vld |=> m_valid && $stable(m_data));
    // R3: bytes appear only after a chip
    p_emit_chip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_valid) |-> $past(chip_vld));
endmodule

bind ppm4_frame_rx ppm4_frame_rx_chk u_chk (.*);

// File: tb/ppm4_frame_rx_bench.sv
module ppm4_frame_rx_bench;
    localparam int          FC      = 16;
    localparam logic [15:0] START   = 16'h0C0C;
    localparam logic [15:0] STOP    = 16'h0CC0;
    localparam int          MAXL    = 16;
    localparam logic [31:0] RESIDUE = 32'hDEBB20E3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chip_vld = 1'b0, chip_in = 1'b0, tx_active = 1'b0, m_ready = 1'b1, stat_clr = 1'b0;
    logic m_valid, stat_end, stat_illegal, stat_crc, stat_len;
    logic [7:0] m_data;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [7:0] got[$];

    always #2.5 clk = ~clk;

    ppm4_frame_rx #(.FLAG_CHIPS(FC), .START_FLAG(START), .STOP_FLAG(STOP), .MAX_LEN(MAXL)) u_ppm4_frame_rx (
        .clk(clk), .rst_n(rst_n), .chip_vld(chip_vld), .chip_in(chip_in), .tx_active(tx_active),
        .m_ready(m_ready), .m_valid(m_valid), .m_data(m_data), .stat_clr(stat_clr),
        .stat_end(stat_end), .stat_illegal(stat_illegal), .stat_crc(stat_crc), .stat_len(stat_len));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r = c;
        for (int i = 0; i < 8; i++) begin
            logic fb = r[0] ^ b[i];
            r = r >> 1;
            if (fb) r = r ^ 32'hEDB88320;
        end
        return r;
    endfunction

    // ---------------- behavioural reference model ----------------
    bit         m_hunt;
    bit         m_win[$];
    int         m_nchips;
    int         m_dibs[$];
    logic [7:0] m_hold[$];
    int         m_nbytes;
    logic [31:0] m_crc;
    bit         e_valid, e_end, e_ill, e_crc, e_len;
    logic [7:0] e_data;

    function automatic bit win_is(input logic [15:0] p);
        for (int i = 0; i < FC; i++) if (m_win[i] != p[FC-1-i]) return 0;
        return 1;
    endfunction

    function automatic void win_zero();
        m_win.delete();
        for (int i = 0; i < FC; i++) m_win.push_back(1'b0);
    endfunction

    always @(posedge clk) begin
        bit s_end, s_ill, s_crc, s_len, emit;
        logic [7:0] em;
        s_end = 0; s_ill = 0; s_crc = 0; s_len = 0; emit = 0; em = 0;
        if (!rst_n) begin
            m_hunt = 1; win_zero(); e_valid = 0; e_data = 0;
            e_end = 0; e_ill = 0; e_crc = 0; e_len = 0;
        end else begin
            if (tx_active) begin
                m_hunt = 1; win_zero();
            end else if (chip_vld) begin
                m_win.push_back(chip_in);
                void'(m_win.pop_front());
                if (m_hunt) begin
                    if (win_is(START)) begin
                        m_hunt = 0; m_nchips = 0; m_dibs.delete(); m_hold.delete();
                        m_nbytes = 0; m_crc = 32'hFFFFFFFF;
                    end
                end else begin
                    m_nchips++;
                    if (m_nchips % 4 == 0 && m_nchips >= FC) begin
                        if (win_is(STOP)) begin
                            m_hunt = 1; s_end = 1;
                            if (m_dibs.size() != 0 || m_nbytes < 4) s_len = 1;
                            else if (m_crc != RESIDUE) s_crc = 1;
                        end else begin
                            int v, d;
                            v = {m_win[0], m_win[1], m_win[2], m_win[3]};
                            d = (v == 8) ? 0 : (v == 4) ? 1 : (v == 2) ? 2 : (v == 1) ? 3 : -1;
                            if (d < 0) begin
                                s_ill = 1; s_end = 1; m_hunt = 1;
                            end else begin
                                m_dibs.push_back(d);
                                if (m_dibs.size() == 4) begin
                                    logic [7:0] b;
                                    b = 8'(m_dibs[0] + 4 * m_dibs[1] + 16 * m_dibs[2] + 64 * m_dibs[3]);
                                    m_dibs.delete();
                                    m_nbytes++;
                                    if (m_nbytes > MAXL + 4) begin
                                        s_len = 1; s_end = 1; m_hunt = 1;
                                    end else begin
                                        m_crc = crc_step(m_crc, b);
                                        m_hold.push_back(b);
                                        if (m_hold.size() > 4) begin emit = 1; em = m_hold.pop_front(); end
                                    end
                                end
                            end
                        end
                    end
                end
            end
            if (emit) begin e_valid = 1; e_data = em; end
            else if (m_ready) e_valid = 0;
            e_end = (e_end && !stat_clr) || s_end;
            e_ill = (e_ill && !stat_clr) || s_ill;
            e_crc = (e_crc && !stat_clr) || s_crc;
            e_len = (e_len && !stat_clr) || s_len;
        end
    end

    // Per-clock comparison, handshake driver and byte collector.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(m_valid == e_valid, "R11 m_valid vs model", m_valid, e_valid);
            if (e_valid) chk(m_data == e_data, "R3 m_data vs model", m_data, e_data);
            chk(stat_end == e_end, "R4 stat_end vs model", stat_end, e_end);
            chk(stat_illegal == e_ill, "R5 stat_illegal vs model", stat_illegal, e_ill);
            chk(stat_crc == e_crc, "R6 stat_crc vs model", stat_crc, e_crc);
            chk(stat_len == e_len, "R8 stat_len vs model", stat_len, e_len);
        end
        m_ready = (cyc % 5) != 0;
        if (rst_n && m_valid && m_ready) got.push_back(m_data);
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic chip(input bit c, input bit clr = 1'b0);
        chip_vld = 1'b1; chip_in = c; stat_clr = clr;
        @(negedge clk);
        chip_vld = 1'b0; stat_clr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic flag(input logic [15:0] p, input bit clr_last = 1'b0);
        for (int i = 15; i >= 0; i--) chip(p[i], clr_last && i == 0);
    endtask

    task automatic sym(input logic [3:0] s);
        for (int i = 3; i >= 0; i--) chip(s[i]);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int k = 0; k < 4; k++) sym(4'b1000 >> b[2*k +: 2]);
    endtask

    task automatic send_body(input logic [7:0] d[$], input bit bad_crc);
        logic [31:0] c = 32'hFFFFFFFF;
        foreach (d[i]) begin send_byte(d[i]); c = crc_step(c, d[i]); end
        c = ~c;
        if (bad_crc) c = c ^ 32'h1;
        for (int k = 0; k < 4; k++) send_byte(c[8*k +: 8]);
    endtask

    task automatic frame(input logic [7:0] d[$], input bit bad_crc, input bit clr_last);
        for (int i = 0; i < 8; i++) chip(1'b0);
        flag(START);
        send_body(d, bad_crc);
        flag(STOP, clr_last);
        for (int i = 0; i < 8; i++) chip(1'b0);
    endtask

    task automatic check_got(input logic [7:0] exp[$], input string tag);
        chk(got.size() == exp.size(), {tag, " byte count"}, got.size(), exp.size());
        foreach (exp[i]) if (i < got.size()) chk(got[i] == exp[i], {tag, " byte value"}, got[i], exp[i]);
        got.delete();
    endtask

    task automatic check_stat(input bit e, input bit il, input bit c, input bit l, input string tag);
        chk(stat_end == e, {tag, " R4 end flag"}, stat_end, e);
        chk(stat_illegal == il, {tag, " R5 illegal flag"}, stat_illegal, il);
        chk(stat_crc == c, {tag, " R6 crc flag"}, stat_crc, c);
        chk(stat_len == l, {tag, " R8 len flag"}, stat_len, l);
    endtask

    task automatic clear_stat();
        stat_clr = 1'b1; @(negedge clk); stat_clr = 1'b0; @(negedge clk);
        check_stat(0, 0, 0, 0, "R10 after read");
    endtask

    initial begin
        logic [7:0] d[$];
        logic [7:0] none[$];
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(m_valid == 1'b0, "R1 m_valid after reset", m_valid, 0);
        check_stat(0, 0, 0, 0, "R1 reset");

        // R2: chips without a start flag produce nothing
        for (int i = 0; i < 4; i++) send_byte(8'hA5);
        flag(STOP);
        check_got(none, "R2 no start flag");
        check_stat(0, 0, 0, 0, "R2 no start flag");

        // R3 R7: good frame, check bytes withheld
        d = '{8'h3C, 8'hA5, 8'h00, 8'hFF, 8'h5A};
        frame(d, 0, 0);
        check_got(d, "R3 R7 good frame");
        check_stat(1, 0, 0, 0, "R4 good frame");
        clear_stat();

        // R7: empty payload
        frame(none, 0, 0);
        check_got(none, "R7 empty frame");
        check_stat(1, 0, 0, 0, "R7 empty frame");
        clear_stat();

        // R6: corrupted check bytes; status left set
        d = '{8'h11, 8'h22, 8'h33};
        frame(d, 1, 0);
        check_got(d, "R6 bad crc");
        check_stat(1, 0, 1, 0, "R6 bad crc");

        // R10: read in the same cycle as the stop flag sets end
        d = '{8'h81, 8'h7E};
        frame(d, 0, 1);
        check_got(d, "R10 collide");
        check_stat(1, 0, 0, 0, "R10 set wins over read");
        clear_stat();

        // R5: illegal symbol after six bytes
        for (int i = 0; i < 8; i++) chip(1'b0);
        flag(START);
        for (int i = 0; i < 6; i++) send_byte(8'(i * 37));
        sym(4'b1100);
        for (int i = 0; i < 3; i++) send_byte(8'h44);
        flag(STOP);
        d = '{8'h00, 8'h25};
        check_got(d, "R5 illegal symbol");
        check_stat(1, 1, 0, 0, "R5 illegal symbol");
        clear_stat();

        // R8: exactly MAX_LEN is fine
        d.delete();
        for (int i = 0; i < MAXL; i++) d.push_back(8'(i * 17 + 3));
        frame(d, 0, 0);
        check_got(d, "R8 max length");
        check_stat(1, 0, 0, 0, "R8 max length");
        clear_stat();

        // R8: one byte over
        d.push_back(8'hC3);
        frame(d, 0, 0);
        d.pop_back();
        check_got(d, "R8 over length");
        check_stat(1, 0, 0, 1, "R8 over length");
        clear_stat();

        // R8: too short
        for (int i = 0; i < 8; i++) chip(1'b0);
        flag(START);
        send_byte(8'h12); send_byte(8'h34);
        flag(STOP);
        check_got(none, "R8 short");
        check_stat(1, 0, 0, 1, "R8 short");
        clear_stat();

        // R8: partial byte before stop
        for (int i = 0; i < 8; i++) chip(1'b0);
        flag(START);
        send_body(none, 0);
        sym(4'b0010);
        flag(STOP);
        check_got(none, "R8 partial");
        check_stat(1, 0, 0, 1, "R8 partial");
        clear_stat();

        // R9: transmitter busy aborts a frame and blocks a full frame
        for (int i = 0; i < 8; i++) chip(1'b0);
        flag(START);
        for (int i = 0; i < 5; i++) send_byte(8'h99);
        tx_active = 1'b1;
        d = '{8'h01, 8'h02};
        frame(d, 0, 0);
        tx_active = 1'b0;
        for (int i = 0; i < 5; i++) send_byte(8'h66);
        flag(STOP);
        check_got(none, "R9 tx busy");
        check_stat(0, 0, 0, 0, "R9 tx busy");

        // R9: recovery after the transmitter releases
        d = '{8'hDE, 8'hAD, 8'hBE, 8'hEF};
        frame(d, 0, 0);
        check_got(d, "R9 recovery");
        check_stat(1, 0, 0, 0, "R9 recovery");

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule